// File: doc/BRIEF.md
# UART Receive FIFO with Per-Byte Error Tags

This block sits after a UART receive shifter and holds received characters until a CPU or DMA engine reads them. On each push it takes one 8-bit character, the parity bit that arrived with it, and the shifter's framing-error and line-overrun indications. It computes a parity-error verdict and stores the character together with three hidden tag bits: parity at bit 8, framing at bit 9 and line overrun at bit 10 of each 11-bit entry. The oldest character is always present on the read port. A status register holds the three tags of that character. The status register loads on the same edge that moves a new character to the read end, so software can read the status first and the data second and get a matching pair.

A not-empty flag supports draining by polling. A service request goes high once the fill level reaches a threshold, so that a DMA channel or an interrupt can move data in bursts. Characters that remain below the threshold have to be drained by polling the not-empty flag. If a push arrives while the queue is full and no read happens in the same cycle, the character is dropped and a sticky overflow flag is set. Only reset clears that flag.

Top module: `rx_tag_fifo`

## Requirements
- R1: Characters leave in the order they were accepted. While the queue holds data, `rd_data` shows the oldest character. Each stored entry is 11 bits: data in bits 7..0, parity tag in bit 8, framing tag in bit 9 and line-overrun tag in bit 10. The framing and line-overrun tags are copies of `in_frm_err` and `in_line_ovr` taken at push time.
- R2: When `par_en`=1 and `par_odd`=0, the parity tag is 1 exactly when the 8 data bits and `in_par_bit` together hold an even number of ones.
- R3: When `par_en`=1 and `par_odd`=1, the parity tag is 1 exactly when the 8 data bits and `in_par_bit` together hold an odd number of ones.
- R4: When `par_en`=0, the parity tag stored with a character is 0.
- R5: After every clock edge, `{st_line_ovr, st_frm_err, st_par_err}` equals the tags of the character at the read end, or 0 when the queue is empty. The status changes only on an edge that brings a new character to the read end: a push into an empty queue, or a pop.
- R6: `not_empty` is 1 exactly when at least one character is held.
- R7: `svc_req` is 1 exactly when the fill level is THRESH (default 5) or more.
- R8: The queue holds DEPTH (default 12) characters. A push while full and without a pop is dropped and sets `fifo_ovr`. `fifo_ovr` stays at 1 until reset.
- R9: A pop while empty changes nothing, and `rd_data` reads 0 while the queue is empty.
- R10: After reset the queue is empty and `rd_data`, every status flag, `not_empty`, `svc_req` and `fifo_ovr` are 0.
- R11: When the queue is full, a push and a pop in the same cycle are both accepted. The fill level stays at DEPTH and `fifo_ovr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_en | input | 1 | Enables the parity check |
| par_odd | input | 1 | Parity sense: 0 flags an even count of ones, 1 flags an odd count |
| in_valid | input | 1 | Push strobe from the receive shifter |
| in_data | input | 8 | Received character |
| in_par_bit | input | 1 | Parity bit received with the character |
| in_frm_err | input | 1 | Framing-error indication for the character |
| in_line_ovr | input | 1 | Line-overrun indication for the character |
| rd_pop | input | 1 | Removes the character at the read end |
| rd_data | output | 8 | Character at the read end, 0 when empty |
| st_par_err | output | 1 | Parity tag of the character at the read end |
| st_frm_err | output | 1 | Framing tag of the character at the read end |
| st_line_ovr | output | 1 | Line-overrun tag of the character at the read end |
| not_empty | output | 1 | At least one character is held |
| svc_req | output | 1 | Fill level is at or above THRESH |
| fifo_ovr | output | 1 | Sticky flag: a push was dropped because the queue was full |

## Verification
The assertions check properties that must hold on every cycle. The fill level never exceeds DEPTH. A dropped push leaves the fill level unchanged. The overflow flag never falls outside reset. An empty pop has no effect. The status flags hold still unless a character moves to the read end, and they clear when the queue drains.

Other behaviour can only be shown by the bench scenarios. These cover the parity verdict for every data value, every parity bit and every parity mode. They also cover the pairing of each tag with its own character through the queue, service-request and not-empty thresholds across a full fill and drain, and push-with-pop at full level. The bench also runs a long mixed push/pop stream and compares it against an arithmetic model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int RXQ_DATA_W = 8;

    typedef logic [RXQ_DATA_W-1:0] rxq_byte_t;

    // Hidden tags: par is entry bit 8, frm bit 9, lovr bit 10
    typedef struct packed {
        logic lovr;
        logic frm;
        logic par;
    } rxq_tags_t;

    typedef struct packed {
        rxq_tags_t tags;
        rxq_byte_t data;
    } rxq_entry_t;

    localparam rxq_tags_t RXQ_NO_TAGS = '{lovr: 1'b0, frm: 1'b0, par: 1'b0};

    // Source of the status register on the next edge
    typedef enum logic [1:0] {
        BOT_HOLD,
        BOT_CLEAR,
        BOT_FROM_IN,
        BOT_FROM_NEXT
    } rxq_bot_sel_e;

    // Parity verdict: odd sense flags an odd count, even sense flags an even count
    function automatic logic rxq_parity_err(input rxq_byte_t d, input logic pbit,
                                            input logic en, input logic odd);
        logic ones_odd;
        ones_odd = ^{d, pbit};
        return en & (odd ? ones_odd : ~ones_odd);
    endfunction

endpackage

// File: rtl/rxq_tagger.sv
module rxq_tagger
    import rxq_pkg::*;
(
    input  logic       par_en,
    input  logic       par_odd,
    input  rxq_byte_t  in_data,
    input  logic       in_par_bit,
    input  logic       in_frm_err,
    input  logic       in_line_ovr,
    output rxq_entry_t ent
);

    always_comb begin
        ent.data      = in_data;
        ent.tags.par  = rxq_parity_err(in_data, in_par_bit, par_en, par_odd);
        ent.tags.frm  = in_frm_err;
        ent.tags.lovr = in_line_ovr;
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 12,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  rxq_entry_t       push_ent,
    input  logic             pop_req,
    output rxq_byte_t        bot_data,
    output rxq_tags_t        nxt_tags,
    output logic [CNT_W-1:0] fill,
    output logic             push_acc,
    output logic             pop_acc,
    output logic             ovr_sticky
);

    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] rd_ptr_inc;
    logic             full;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full       = (fill == CNT_W'(DEPTH));
    assign pop_acc    = pop_req && (fill != '0);
    assign push_acc   = push_req && (!full || pop_acc);
    assign rd_ptr_inc = bump(rd_ptr);
    assign bot_data   = mem[rd_ptr].data;
    assign nxt_tags   = mem[rd_ptr_inc].tags;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            fill       <= '0;
            ovr_sticky <= 1'b0;
        end else begin
            if (push_acc) wr_ptr <= bump(wr_ptr);
            if (pop_acc)  rd_ptr <= rd_ptr_inc;
            case ({push_acc, pop_acc})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
            if (push_req && !push_acc) ovr_sticky <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_acc) mem[wr_ptr] <= push_ent;
    end

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && full) |=> $stable(fill));

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_sticky |=> ovr_sticky);

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && fill == '0) |=> (fill == '0));

    // R11
    full_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && full) |=> (full && $stable(ovr_sticky)));

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_acc,
    input  logic             pop_acc,
    input  logic [CNT_W-1:0] fill,
    input  rxq_tags_t        in_tags,
    input  rxq_tags_t        nxt_tags,
    output rxq_tags_t        st_tags
);

    rxq_bot_sel_e sel;

    always_comb begin
        if (fill == '0) begin
            sel = push_acc ? BOT_FROM_IN : BOT_CLEAR;
        end else if (pop_acc) begin
            if (fill == CNT_W'(1)) sel = push_acc ? BOT_FROM_IN : BOT_CLEAR;
            else                   sel = BOT_FROM_NEXT;
        end else begin
            sel = BOT_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_tags <= RXQ_NO_TAGS;
        end else begin
            case (sel)
                BOT_CLEAR:     st_tags <= RXQ_NO_TAGS;
                BOT_FROM_IN:   st_tags <= in_tags;
                BOT_FROM_NEXT: st_tags <= nxt_tags;
                default:       st_tags <= st_tags;
            endcase
        end
    end

    // R5
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fill != '0 && !pop_acc) |=> $stable(st_tags));

    // R5
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (fill == '0 && !push_acc) |=> (st_tags == RXQ_NO_TAGS));

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 12,
    parameter int THRESH = 5,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_par_bit,
    input  logic       in_frm_err,
    input  logic       in_line_ovr,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       st_par_err,
    output logic       st_frm_err,
    output logic       st_line_ovr,
    output logic       not_empty,
    output logic       svc_req,
    output logic       fifo_ovr
);

    rxq_entry_t       in_ent;
    rxq_byte_t        bot_data;
    rxq_tags_t        nxt_tags;
    rxq_tags_t        st_tags;
    logic [CNT_W-1:0] fill;
    logic             push_acc;
    logic             pop_acc;

    rxq_tagger u_tagger (
        .par_en      (par_en),
        .par_odd     (par_odd),
        .in_data     (in_data),
        .in_par_bit  (in_par_bit),
        .in_frm_err  (in_frm_err),
        .in_line_ovr (in_line_ovr),
        .ent         (in_ent)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push_req   (in_valid),
        .push_ent   (in_ent),
        .pop_req    (rd_pop),
        .bot_data   (bot_data),
        .nxt_tags   (nxt_tags),
        .fill       (fill),
        .push_acc   (push_acc),
        .pop_acc    (pop_acc),
        .ovr_sticky (fifo_ovr)
    );

    rxq_status #(.CNT_W(CNT_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .push_acc (push_acc),
        .pop_acc  (pop_acc),
        .fill     (fill),
        .in_tags  (in_ent.tags),
        .nxt_tags (nxt_tags),
        .st_tags  (st_tags)
    );

    assign not_empty   = (fill != '0);
    assign svc_req     = (fill >= CNT_W'(THRESH));
    assign rd_data     = not_empty ? bot_data : '0;
    assign st_par_err  = st_tags.par;
    assign st_frm_err  = st_tags.frm;
    assign st_line_ovr = st_tags.lovr;

    // R9
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !not_empty |-> (rd_data == 8'h00 && st_tags == RXQ_NO_TAGS));

    // R4
    par_off_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (push_acc && fill == '0 && !par_en) |=> !st_par_err);

    // R7
    svc_implies_data_chk: assert property (@(posedge clk) disable iff (rst)
        svc_req |-> not_empty);

endmodule

// File: tb/test_rx_tag_fifo.sv
module test_rx_tag_fifo;

    localparam int DEPTH  = 12;
    localparam int THRESH = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       par_en = 1'b0, par_odd = 1'b0;
    logic       in_valid = 1'b0, in_par_bit = 1'b0, in_frm_err = 1'b0, in_line_ovr = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       st_par_err, st_frm_err, st_line_ovr, not_empty, svc_req, fifo_ovr;

    rx_tag_fifo #(.DEPTH(DEPTH), .THRESH(THRESH)) i_rx_tag_fifo (
        .clk(clk), .rst(rst), .par_en(par_en), .par_odd(par_odd),
        .in_valid(in_valid), .in_data(in_data), .in_par_bit(in_par_bit),
        .in_frm_err(in_frm_err), .in_line_ovr(in_line_ovr), .rd_pop(rd_pop),
        .rd_data(rd_data), .st_par_err(st_par_err), .st_frm_err(st_frm_err),
        .st_line_ovr(st_line_ovr), .not_empty(not_empty), .svc_req(svc_req),
        .fifo_ovr(fifo_ovr)
    );

    // 250 MHz: 4 time units per period
    always #2 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model: entries {lovr, frm, par, data}
    logic [10:0] q [0:15];
    int          qc    = 0;
    logic        m_ovr = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [10:0] act, input logic [10:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] d, input logic pb,
                                     input logic en, input logic odd);
        int ones;
        ones = pb;
        for (int i = 0; i < 8; i++) ones += d[i];
        if (!en) return 1'b0;
        return odd ? (ones % 2 == 1) : (ones % 2 == 0);
    endfunction

    task automatic check_all(input string ctx);
        logic [10:0] head;
        head = (qc > 0) ? q[0] : 11'h000;
        chk("R1", "rd_data", rd_data, head[7:0]);
        chk("R5", "status tags", {st_line_ovr, st_frm_err, st_par_err}, head[10:8]);
        chk(ctx, "parity flag", st_par_err, head[8]);
        chk("R6", "not_empty", not_empty, qc > 0);
        chk("R7", "svc_req", svc_req, qc >= THRESH);
        chk("R8", "fifo_ovr", fifo_ovr, m_ovr);
    endtask

    task automatic cyc(input logic push, input logic [7:0] d, input logic pb,
                       input logic fr, input logic lo, input logic pop,
                       input string ctx);
        bit pe, acc;
        @(negedge clk);
        in_valid = push; in_data = d; in_par_bit = pb;
        in_frm_err = fr; in_line_ovr = lo; rd_pop = pop;
        @(posedge clk);
        pe  = pop && qc > 0;
        acc = push && (qc < DEPTH || pe);
        if (push && !acc) m_ovr = 1'b1;
        if (pe) begin
            for (int i = 0; i < 15; i++) q[i] = q[i+1];
            qc--;
        end
        if (acc) begin
            q[qc] = {lo, fr, exp_par(d, pb, par_en, par_odd), d};
            qc++;
        end
        #1;
        check_all(ctx);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; rd_pop = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        qc = 0; m_ovr = 1'b0;
        #1;
        // R10 reset state
        check_all("R10");
        chk("R10", "rd_data after reset", rd_data, 11'h000);
        chk("R10", "fifo_ovr after reset", fifo_ovr, 11'h000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        bit          phase;
        string       ctx;
        do_reset();

        // R2 R3 R4: every byte, parity bit and mode; tags ride with the byte (R1)
        for (int en = 0; en < 2; en++) begin
            for (int od = 0; od < 2; od++) begin
                par_en = en[0]; par_odd = od[0];
                ctx = (en == 0) ? "R4" : ((od == 0) ? "R2" : "R3");
                for (int d = 0; d < 256; d++) begin
                    for (int pb = 0; pb < 2; pb++) begin
                        cyc(1'b1, d[7:0], pb[0], d[0], d[1], 1'b0, ctx);
                        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, ctx);
                    end
                end
            end
        end

        // R8 R7 R6: fill past depth, overflow sets
        par_en = 1'b1; par_odd = 1'b0;
        for (int k = 0; k < DEPTH + 2; k++)
            cyc(1'b1, 8'hA0 + k[7:0], k[0], k[1], k[2], 1'b0, "R8");
        // R11: push and pop at full
        cyc(1'b1, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b1, "R11");
        chk("R11", "still full", svc_req && not_empty, 11'h001);
        for (int k = 0; k < DEPTH; k++)
            cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
        // R9: pops on an empty queue
        for (int k = 0; k < 3; k++)
            cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
        cyc(1'b1, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, "R9");

        // R5: mixed stream with alternating fill bias and changing parity modes
        r = 32'h1234_5678;
        for (int i = 0; i < 4000; i++) begin
            r = r * 32'd1103515245 + 32'd12345;
            phase = ((i / 150) % 2) == 0;
            par_en = r[27]; par_odd = r[28];
            cyc(phase ? (r[20:19] != 2'b00) : r[20], r[15:8], r[23], r[24], r[25],
                phase ? (r[21] & r[22]) : (r[22:21] != 2'b00), "R5");
        end

        // R10: reset clears the sticky overflow and the queue
        do_reset();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule